// File: doc/BRIEF.md
# Presentation Timestamp Synchronizer

This block keeps a local 90 kHz presentation clock and uses it to decide whether a video or audio decoder should drop or replay its current presentation unit. The unit is one frame for video and 64 samples per channel for audio. A 27 MHz clock-enable pulse is divided by a programmable ratio (300 by default) to advance a 33-bit time counter. The counter does not run until the first timestamp of either stream arrives, and that timestamp becomes its starting value.

Each arriving timestamp is compared with a reference. The difference is taken modulo 2^33 and read as a signed value, so wraparound of the counter is harmless. A timestamp ahead of the reference by more than the stream's threshold asks for a repeat. A timestamp behind it by more than the threshold asks for a skip. The reference depends on the mode:
- In system-time mode, both streams use the counter.
- In audio-led mode, video timestamps use the most recent audio timestamp, and audio gets no actions.
- In manual mode, timestamps produce no actions and commands issued by the host are passed through.

Top module: `av_sync_engine`

## Requirements
- R1: After reset the mode is system-time, `stc_valid_o` is 0, `stc_o` is 0, and no action strobe is high.
- R2: The first timestamp strobe after reset loads `stc_o` with that timestamp and sets `stc_valid_o`. If both strobes arrive in that cycle, the video value is loaded. Later strobes do not reload the counter.
- R3: Once loaded, `stc_o` advances by exactly 1 for every DIV cycles in which `tick_27m_i` is high, holds while the enable is low, and wraps from 2^33-1 to 0.
- R4: In system-time mode, a strobe with signed difference d = (pts - stc) mod 2^33 produces an action strobe one cycle later:
  - If d > threshold, the action is repeat (code 2'b10).
  - If -d > threshold, the action is skip (code 2'b01).
  - Otherwise there is no strobe.
  - On the loading cycle the compare uses the newly loaded value.
- R5: A difference whose magnitude equals the threshold produces no action.
- R6: The difference is taken modulo 2^33: near wraparound, a timestamp just past zero counts as later and a timestamp just below 2^33 counts as earlier.
- R7: Video and audio strobes in the same cycle are judged independently, and both action outputs can fire in the same cycle.
- R8: In audio-led mode:
  - Video timestamps are judged against the last audio timestamp latched in an earlier cycle.
  - A video timestamp that arrives before any audio timestamp produces no action.
  - Audio strobes never produce an action.
- R9: In manual mode, timestamp strobes produce no action. A host command of skip (01) or repeat (10) appears on the matching action output one cycle later. Host codes 00 and 11 are ignored.
- R10: Outside manual mode, host commands produce no action.
- R11: `mode_wr_i` loads the mode from `mode_sel_i`, and the new mode takes effect from the next cycle. The codes are 00 system-time, 01 audio-led and 10 manual; 11 acts as system-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_27m_i | input | 1 | 27 MHz rate enable |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_sel_i | input | 2 | Mode code to write |
| vid_thresh_i | input | 33 | Video drift limit in 90 kHz ticks |
| aud_thresh_i | input | 33 | Audio drift limit in 90 kHz ticks |
| vid_pts_vld_i | input | 1 | Video timestamp strobe |
| vid_pts_i | input | 33 | Video timestamp |
| aud_pts_vld_i | input | 1 | Audio timestamp strobe |
| aud_pts_i | input | 33 | Audio timestamp |
| host_vid_cmd_vld_i | input | 1 | Host video command strobe |
| host_vid_cmd_i | input | 2 | Host video command code |
| host_aud_cmd_vld_i | input | 1 | Host audio command strobe |
| host_aud_cmd_i | input | 2 | Host audio command code |
| stc_o | output | 33 | Local 90 kHz time |
| stc_valid_o | output | 1 | Time counter has been loaded |
| vid_act_vld_o | output | 1 | Video action strobe |
| vid_act_o | output | 2 | Video action code |
| aud_act_vld_o | output | 1 | Audio action strobe |
| aud_act_o | output | 2 | Audio action code |

## Verification
Two events can land in the same cycle, and the bench provokes both.

The first pair is counter loading and drift judgement. Right after reset, video and audio timestamps are strobed together. The bench expects the video value to be loaded and the audio timestamp to be judged against it. It predicts the audio action from the signed difference between the two values.

The second pair is the two streams' comparisons. With the counter frozen, both streams are strobed together with opposite drifts. The bench expects a skip on one output and a repeat on the other in the same cycle.

// File: rtl/av_sync_pkg.sv
package av_sync_pkg;

    localparam int TS_W = 33;

    typedef enum logic [1:0] {
        MODE_SYSTIME  = 2'b00,
        MODE_AUDLEAD  = 2'b01,
        MODE_MANUAL   = 2'b10
    } sync_mode_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_SKIP   = 2'b01,
        ACT_REPEAT = 2'b10
    } sync_act_t;

    function automatic sync_mode_t decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return MODE_AUDLEAD;
            2'b10:   return MODE_MANUAL;
            default: return MODE_SYSTIME;
        endcase
    endfunction

endpackage

// File: rtl/av_timebase.sv
module av_timebase
    import av_sync_pkg::*;
#(
    parameter int DIV = 300
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            vid_vld_i,
    input  logic [TS_W-1:0] vid_pts_i,
    input  logic            aud_vld_i,
    input  logic [TS_W-1:0] aud_pts_i,
    output logic [TS_W-1:0] stc_o,
    output logic [TS_W-1:0] stc_now_o,
    output logic            seeded_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0]   presc;
        logic [TS_W-1:0] stc;
        logic            seeded;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic            load_now;
    logic [TS_W-1:0] seed_val;

    assign load_now = (vid_vld_i || aud_vld_i) && !st_q.seeded;
    assign seed_val = vid_vld_i ? vid_pts_i : aud_pts_i;

    always_comb begin
        st_d = st_q;
        if (load_now) begin
            st_d.stc    = seed_val;
            st_d.presc  = '0;
            st_d.seeded = 1'b1;
        end else if (st_q.seeded && tick_i) begin
            if (st_q.presc == PLAST) begin
                st_d.presc = '0;
                st_d.stc   = st_q.stc + 1'b1;
            end else begin
                st_d.presc = st_q.presc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stc_o     = st_q.stc;
    assign seeded_o  = st_q.seeded;
    assign stc_now_o = load_now ? seed_val : st_q.stc;

    a_r3_presc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.presc <= PLAST);

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seeded && !load_now |=> (st_q.stc == $past(st_q.stc)) || (st_q.stc == $past(st_q.stc) + 1'b1));

    a_r2_seed_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seeded |=> st_q.seeded);

    a_r2_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seeded && !tick_i |=> $stable(st_q.stc));

endmodule

// File: rtl/av_drift_cmp.sv
module av_drift_cmp
    import av_sync_pkg::*;
(
    input  logic            en_i,
    input  logic [TS_W-1:0] pts_i,
    input  logic [TS_W-1:0] ref_i,
    input  logic [TS_W-1:0] thresh_i,
    output sync_act_t       act_o
);
    logic [TS_W-1:0] diff;
    logic [TS_W-1:0] mag;
    logic            behind;

    always_comb begin
        diff   = pts_i - ref_i;
        behind = diff[TS_W-1];
        mag    = behind ? (~diff + 1'b1) : diff;
        act_o  = ACT_NONE;
        if (en_i && (mag > thresh_i)) begin
            act_o = behind ? ACT_SKIP : ACT_REPEAT;
        end
    end

endmodule

// File: rtl/av_sync_engine.sv
module av_sync_engine
    import av_sync_pkg::*;
#(
    parameter int DIV = 300
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_27m_i,
    input  logic            mode_wr_i,
    input  logic [1:0]      mode_sel_i,
    input  logic [TS_W-1:0] vid_thresh_i,
    input  logic [TS_W-1:0] aud_thresh_i,
    input  logic            vid_pts_vld_i,
    input  logic [TS_W-1:0] vid_pts_i,
    input  logic            aud_pts_vld_i,
    input  logic [TS_W-1:0] aud_pts_i,
    input  logic            host_vid_cmd_vld_i,
    input  logic [1:0]      host_vid_cmd_i,
    input  logic            host_aud_cmd_vld_i,
    input  logic [1:0]      host_aud_cmd_i,
    output logic [TS_W-1:0] stc_o,
    output logic            stc_valid_o,
    output logic            vid_act_vld_o,
    output logic [1:0]      vid_act_o,
    output logic            aud_act_vld_o,
    output logic [1:0]      aud_act_o
);
    typedef struct packed {
        sync_mode_t      mode;
        logic [TS_W-1:0] aud_ref;
        logic            aud_ref_vld;
        logic            vid_vld;
        sync_act_t       vid_act;
        logic            aud_vld;
        sync_act_t       aud_act;
    } eng_state_t;

    eng_state_t      st_d, st_q;
    logic [TS_W-1:0] stc_now;
    logic [TS_W-1:0] vid_ref;
    sync_act_t       vid_cmp, aud_cmp;
    logic            vid_cmp_en, aud_cmp_en;
    sync_act_t       host_vid_act, host_aud_act;

    av_timebase #(.DIV(DIV)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_27m_i),
        .vid_vld_i (vid_pts_vld_i),
        .vid_pts_i (vid_pts_i),
        .aud_vld_i (aud_pts_vld_i),
        .aud_pts_i (aud_pts_i),
        .stc_o     (stc_o),
        .stc_now_o (stc_now),
        .seeded_o  (stc_valid_o)
    );

    assign vid_ref    = (st_q.mode == MODE_AUDLEAD) ? st_q.aud_ref : stc_now;
    assign vid_cmp_en = vid_pts_vld_i &&
                        ((st_q.mode == MODE_SYSTIME) ||
                         (st_q.mode == MODE_AUDLEAD && st_q.aud_ref_vld));
    assign aud_cmp_en = aud_pts_vld_i && (st_q.mode == MODE_SYSTIME);

    av_drift_cmp u_vid_cmp (
        .en_i     (vid_cmp_en),
        .pts_i    (vid_pts_i),
        .ref_i    (vid_ref),
        .thresh_i (vid_thresh_i),
        .act_o    (vid_cmp)
    );

    av_drift_cmp u_aud_cmp (
        .en_i     (aud_cmp_en),
        .pts_i    (aud_pts_i),
        .ref_i    (stc_now),
        .thresh_i (aud_thresh_i),
        .act_o    (aud_cmp)
    );

    always_comb begin
        host_vid_act = ACT_NONE;
        host_aud_act = ACT_NONE;
        if (host_vid_cmd_vld_i && (host_vid_cmd_i == ACT_SKIP || host_vid_cmd_i == ACT_REPEAT))
            host_vid_act = sync_act_t'(host_vid_cmd_i);
        if (host_aud_cmd_vld_i && (host_aud_cmd_i == ACT_SKIP || host_aud_cmd_i == ACT_REPEAT))
            host_aud_act = sync_act_t'(host_aud_cmd_i);
    end

    always_comb begin
        st_d         = st_q;
        st_d.vid_vld = 1'b0;
        st_d.vid_act = ACT_NONE;
        st_d.aud_vld = 1'b0;
        st_d.aud_act = ACT_NONE;
        if (mode_wr_i) st_d.mode = decode_mode(mode_sel_i);
        if (aud_pts_vld_i) begin
            st_d.aud_ref     = aud_pts_i;
            st_d.aud_ref_vld = 1'b1;
        end
        if (st_q.mode == MODE_MANUAL) begin
            st_d.vid_act = host_vid_act;
            st_d.aud_act = host_aud_act;
        end else begin
            st_d.vid_act = vid_cmp;
            st_d.aud_act = aud_cmp;
        end
        st_d.vid_vld = (st_d.vid_act != ACT_NONE);
        st_d.aud_vld = (st_d.aud_act != ACT_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_SYSTIME;
        end else begin
            st_q <= st_d;
        end
    end

    assign vid_act_vld_o = st_q.vid_vld;
    assign vid_act_o     = st_q.vid_act;
    assign aud_act_vld_o = st_q.aud_vld;
    assign aud_act_o     = st_q.aud_act;

    a_r4_vid_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        vid_act_vld_o |-> (vid_act_o == ACT_SKIP || vid_act_o == ACT_REPEAT));

    a_r4_vid_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_pts_vld_i && !host_vid_cmd_vld_i |=> !vid_act_vld_o);

    a_r8_audio_quiet_when_led: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_AUDLEAD |=> !aud_act_vld_o);

    a_r9_manual_relay: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode == MODE_MANUAL && host_vid_cmd_vld_i && host_vid_cmd_i == ACT_SKIP
        |=> vid_act_vld_o && vid_act_o == ACT_SKIP);

    a_r10_host_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode != MODE_MANUAL && !aud_pts_vld_i |=> !aud_act_vld_o);

endmodule

// File: tb/av_sync_engine_tb.sv
module av_sync_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 300;
    localparam logic [32:0] TOP = 33'h1_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        mode_wr;
    logic [1:0]  mode_sel;
    logic [32:0] vthr, athr;
    logic        vvld, avld;
    logic [32:0] vpts, apts;
    logic        hvv, hav;
    logic [1:0]  hvc, hac;
    logic [32:0] stc;
    logic        stc_valid;
    logic        vact_vld, aact_vld;
    logic [1:0]  vact, aact;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    av_sync_engine #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_27m_i(tick),
        .mode_wr_i(mode_wr), .mode_sel_i(mode_sel),
        .vid_thresh_i(vthr), .aud_thresh_i(athr),
        .vid_pts_vld_i(vvld), .vid_pts_i(vpts),
        .aud_pts_vld_i(avld), .aud_pts_i(apts),
        .host_vid_cmd_vld_i(hvv), .host_vid_cmd_i(hvc),
        .host_aud_cmd_vld_i(hav), .host_aud_cmd_i(hac),
        .stc_o(stc), .stc_valid_o(stc_valid),
        .vid_act_vld_o(vact_vld), .vid_act_o(vact),
        .aud_act_vld_o(aact_vld), .aud_act_o(aact)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [32:0] p, input logic [32:0] r, input logic [32:0] t);
        logic [32:0] d, m;
        d = p - r;
        m = d[32] ? (~d + 1'b1) : d;
        if (m > t) return d[32] ? 3'b101 : 3'b110;
        return 3'b000;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle();
        vvld = 0; avld = 0; hvv = 0; hav = 0; mode_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; tick = 0; idle(); mode_sel = 0; vpts = 0; apts = 0; hvc = 0; hac = 0;
        vthr = 33'd100; athr = 33'd50;
        step(3);
        rst_n = 1;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_wr = 1; mode_sel = m; step(1); mode_wr = 0;
    endtask

    task automatic strobe(input logic v, input logic [32:0] vp, input logic a, input logic [32:0] ap);
        vvld = v; vpts = vp; avld = a; apts = ap;
        step(1);
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 stc", stc, 0);
        chk("R1 stc_valid", stc_valid, 0);
        chk("R1 vid strobe", vact_vld, 0);
        chk("R1 aud strobe", aact_vld, 0);
    endtask

    task automatic t_seed_same_cycle();
        logic [2:0] e;
        do_reset();
        strobe(1, 33'd5000, 1, 33'd4800);
        e = model(33'd4800, 33'd5000, athr);
        chk("R2 seed video wins", stc, 33'd5000);
        chk("R2 valid", stc_valid, 1);
        chk("R7 aud judged at seed vld", aact_vld, e[2]);
        chk("R7 aud judged at seed code", aact, e[1:0]);
        chk("R4 vid zero drift at seed", vact_vld, 0);
        strobe(1, 33'd9000, 0, 0);
        chk("R2 no reload", stc, 33'd5000);
    endtask

    task automatic t_timebase();
        do_reset();
        strobe(0, 0, 1, 33'd1000);
        tick = 1;
        step(DIV - 1);
        chk("R3 before step", stc, 33'd1000);
        step(1);
        chk("R3 one step", stc, 33'd1001);
        step(DIV);
        chk("R3 two steps", stc, 33'd1002);
        tick = 0;
        step(DIV + 5);
        chk("R3 hold without enable", stc, 33'd1002);
    endtask

    task automatic t_systime();
        do_reset();
        strobe(1, 33'd10000, 0, 0);
        strobe(1, 33'd10101, 0, 0);
        chk("R4 repeat vld", vact_vld, 1);
        chk("R4 repeat code", vact, 2'b10);
        step(1);
        chk("R4 strobe one cycle", vact_vld, 0);
        strobe(1, 33'd9899, 0, 0);
        chk("R4 skip code", {vact_vld, vact}, 3'b101);
        strobe(1, 33'd10100, 0, 0);
        chk("R5 equal ahead no action", vact_vld, 0);
        strobe(1, 33'd9900, 0, 0);
        chk("R5 equal behind no action", vact_vld, 0);
        strobe(0, 0, 1, 33'd10051);
        chk("R4 audio repeat", {aact_vld, aact}, 3'b110);
        strobe(1, 33'd10200, 1, 33'd9000);
        chk("R7 video side", {vact_vld, vact}, 3'b110);
        chk("R7 audio side", {aact_vld, aact}, 3'b101);
        hvv = 1; hvc = 2'b01; hav = 1; hac = 2'b10; step(1); idle();
        chk("R10 host video ignored", vact_vld, 0);
        chk("R10 host audio ignored", aact_vld, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        vthr = 33'd3;
        strobe(1, TOP, 0, 0);
        tick = 1; step(DIV); tick = 0;
        chk("R3 wrap to zero", stc, 0);
        strobe(1, 33'd5, 0, 0);
        chk("R6 past zero is later", {vact_vld, vact}, 3'b110);
        strobe(1, TOP - 33'd3, 0, 0);
        chk("R6 below top is earlier", {vact_vld, vact}, 3'b101);
    endtask

    task automatic t_audlead();
        do_reset();
        set_mode(2'b01);
        strobe(1, 33'd20000, 0, 0);
        chk("R8 no audio ref no action", vact_vld, 0);
        strobe(0, 0, 1, 33'd50000);
        chk("R8 audio quiet", aact_vld, 0);
        strobe(1, 33'd50101, 0, 0);
        chk("R8 video vs audio repeat", {vact_vld, vact}, 3'b110);
        strobe(1, 33'd49800, 0, 0);
        chk("R8 video vs audio skip", {vact_vld, vact}, 3'b101);
        strobe(1, 33'd50050, 0, 0);
        chk("R8 within limit", vact_vld, 0);
    endtask

    task automatic t_manual();
        do_reset();
        strobe(1, 33'd1000, 0, 0);
        set_mode(2'b10);
        strobe(1, 33'd90000, 1, 33'd2);
        chk("R9 video pts ignored", vact_vld, 0);
        chk("R9 audio pts ignored", aact_vld, 0);
        hvv = 1; hvc = 2'b10; hav = 1; hac = 2'b01; step(1); idle();
        chk("R9 host video relay", {vact_vld, vact}, 3'b110);
        chk("R9 host audio relay", {aact_vld, aact}, 3'b101);
        hvv = 1; hvc = 2'b11; hav = 1; hac = 2'b00; step(1); idle();
        chk("R9 host code 11 ignored", vact_vld, 0);
        chk("R9 host code 00 ignored", aact_vld, 0);
    endtask

    task automatic t_mode_code3();
        do_reset();
        set_mode(2'b10);
        set_mode(2'b11);
        strobe(1, 33'd500, 0, 0);
        strobe(1, 33'd900, 0, 0);
        chk("R11 code 11 is system time", {vact_vld, vact}, 3'b110);
        mode_wr = 1; mode_sel = 2'b10; vvld = 1; vpts = 33'd100;
        step(1); idle();
        chk("R11 write takes effect next cycle", {vact_vld, vact}, 3'b101);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_seed_same_cycle();
                t_timebase();
                t_systime();
                t_wrap();
                t_audlead();
                t_manual();
                t_mode_code3();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule